// File: doc/BRIEF.md
# Streaming Sobel Edge Detector

This block turns a raster stream of 24-bit colour pixels into an edge-strength image. It takes at most one pixel per clock. Each pixel is reduced to an 8-bit brightness value. Two earlier image lines are held in on-chip line stores. A 3x3 neighbourhood slides along the current line, and the block computes the Sobel gradient strength of that neighbourhood. The result is written to all three colour channels of the output pixel, which gives a grey edge map that any RGB consumer can take.

The neighbourhood of a pixel is only complete once the line below it and the column to its right have arrived. For that reason the upstream source walks a scan grid one row taller and one column wider than the image. Each valid beat is one scan position. On the extra (flush) positions the colour data is don't-care. The output for image pixel (r-1, c-1) leaves one clock after scan position (r, c). The image size is set at run time through the two size inputs, up to the maximum set by the parameters. A frame-start flag and a line-end flag let the source resynchronise the scan counters.

Top module: `sobel_edge_stream`

## Requirements
- R1: Input pixels are packed as {red[23:16], green[15:8], blue[7:0]}. Brightness is computed as (77*red + 150*green + 29*blue) >> 8.
- R2: Each cycle with `in_valid` high is one scan position (r, c), with r in 0..rows and c in 0..cols. Positions with r >= 1 and c >= 1 raise `out_valid` in the next clock with the result for image pixel (r-1, c-1). Positions in scan row 0 or scan column 0 produce no output.
- R3: For a non-border pixel the result is |Gx| + |Gy| over its 3x3 brightness neighbourhood. Gx weights the columns left to right with rows {-1,0,1}, {-2,0,2}, {-1,0,1}. Gy is the transpose of Gx (top row negative, bottom row positive).
- R4: A sum above 255 is clipped to 255.
- R5: Pixels in the first or last image row, or in the first or last image column, produce 0, even when their neighbourhood holds a strong edge.
- R6: `out_rgb` carries the same 8-bit result in all three channel fields.
- R7: A beat with `in_sof` high is scan position (0, 0), whatever the counters held. This lets a new frame cut off a partly sent one.
- R8: The scan column wraps to 0, and the scan row advances, after a beat whose column equals `cfg_cols` or that carries `in_eol`, whichever comes first. The scan row wraps to 0 after scan row `cfg_rows`.
- R9: Cycles with `in_valid` low move no counter, store no data, raise no `out_valid` and leave `out_rgb` unchanged, whatever `in_rgb`, `in_sof` and `in_eol` hold.
- R10: While reset is applied and after it, `out_valid` is 0 and `out_rgb` is 0 until the first output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_cols | input | 12 | Image width in pixels (default parameters) |
| cfg_rows | input | 12 | Image height in lines (default parameters) |
| in_valid | input | 1 | Beat strobe: one scan position |
| in_sof | input | 1 | This beat is scan position (0, 0) |
| in_eol | input | 1 | This beat ends its scan row |
| in_rgb | input | 24 | Input pixel {red, green, blue} |
| out_valid | output | 1 | Output pixel strobe |
| out_rgb | output | 24 | Edge strength replicated into three channels |

## Verification
Border forcing and clipping can hit the same output pixel. A white area that starts at image column 1 puts the strongest gradient right next to the left border. Its neighbours inside the image clip to 255, while the border column itself must read 0. A checkerboard does the same along the last row and last column. A second collision occurs when a frame-start beat arrives in the middle of a scan row of an unfinished frame: the restart must win over the running counters. The scoreboard checks this by expecting exactly the outputs of the cut-off beats and then a clean new frame.

// File: rtl/sobel_edge_pkg.sv
package sobel_edge_pkg;
  localparam int PIX_W  = 8;
  localparam int GRAD_W = PIX_W + 4;
  localparam int LUMA_KR = 77;
  localparam int LUMA_KG = 150;
  localparam int LUMA_KB = 29;

  typedef logic [PIX_W-1:0] pix_t;

  typedef struct packed {
    pix_t red;
    pix_t grn;
    pix_t blu;
  } rgb_t;
endpackage

// File: rtl/sobel_luma.sv
module sobel_luma
  import sobel_edge_pkg::*;
(
  input  rgb_t pix_i,
  output pix_t luma_o
);
  localparam int ACC_W = 2 * PIX_W;

  logic [ACC_W-1:0] acc;

  // R1: weighted brightness, scaled by 1/256
  always_comb begin
    acc = ACC_W'(LUMA_KR) * {{PIX_W{1'b0}}, pix_i.red}
        + ACC_W'(LUMA_KG) * {{PIX_W{1'b0}}, pix_i.grn}
        + ACC_W'(LUMA_KB) * {{PIX_W{1'b0}}, pix_i.blu};
  end

  assign luma_o = acc[ACC_W-1:PIX_W];
endmodule

// File: rtl/sobel_line_store.sv
module sobel_line_store
  import sobel_edge_pkg::*;
#(
  parameter  int DEPTH = 2048,
  parameter  int LINES = 2,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic                  clk,
  input  logic                  wr_en,
  input  logic [AW-1:0]         addr,
  input  pix_t                  din,
  output pix_t [LINES-1:0]      taps_o
);
  // chain[k] is written into line k; chain[k+1] is what line k held
  pix_t [LINES:0] chain;

  assign chain[0] = din;

  for (genvar k = 0; k < LINES; k++) begin : g_line
    pix_t mem [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en) begin
        mem[addr] <= chain[k];
      end
    end

    assign chain[k+1] = mem[addr];
    assign taps_o[k]  = chain[k+1];
  end
endmodule

// File: rtl/sobel_window.sv
module sobel_window
  import sobel_edge_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic shift_en,
  input  pix_t top_i,
  input  pix_t mid_i,
  input  pix_t bot_i,
  output pix_t mag_o
);
  // index 0 = top row, 2 = bottom row
  pix_t [2:0] near_q, far_q, near_n, far_n, fresh;

  assign fresh = {bot_i, mid_i, top_i};

  always_comb begin
    near_n = near_q;
    far_n  = far_q;
    if (shift_en) begin
      far_n  = near_q;
      near_n = fresh;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      near_q <= '0;
      far_q  <= '0;
    end else begin
      near_q <= near_n;
      far_q  <= far_n;
    end
  end

  function automatic logic signed [GRAD_W-1:0] ext(input pix_t p);
    return $signed({{(GRAD_W-PIX_W){1'b0}}, p});
  endfunction

  // w[row][col], col 0 = oldest
  logic signed [GRAD_W-1:0] w [3][3];
  logic signed [GRAD_W-1:0] gx, gy, ax, ay;
  logic        [GRAD_W-1:0] sum;

  always_comb begin
    for (int i = 0; i < 3; i++) begin
      w[i][0] = ext(far_q[i]);
      w[i][1] = ext(near_q[i]);
      w[i][2] = ext(fresh[i]);
    end
    gx  = (w[0][2] + 2*w[1][2] + w[2][2]) - (w[0][0] + 2*w[1][0] + w[2][0]);
    gy  = (w[2][0] + 2*w[2][1] + w[2][2]) - (w[0][0] + 2*w[0][1] + w[0][2]);
    ax  = (gx < 0) ? -gx : gx;
    ay  = (gy < 0) ? -gy : gy;
    sum = $unsigned(ax) + $unsigned(ay);
  end

  assign mag_o = (sum > GRAD_W'(255)) ? pix_t'(255) : sum[PIX_W-1:0];
endmodule

// File: rtl/sobel_edge_stream.sv
module sobel_edge_stream
  import sobel_edge_pkg::*;
#(
  parameter  int MAX_COLS = 2048,
  parameter  int MAX_ROWS = 2048,
  localparam int CW = $clog2(MAX_COLS + 1),
  localparam int RW = $clog2(MAX_ROWS + 1),
  localparam int AW = $clog2(MAX_COLS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cfg_cols,
  input  logic [RW-1:0] cfg_rows,
  input  logic          in_valid,
  input  logic          in_sof,
  input  logic          in_eol,
  input  logic [23:0]   in_rgb,
  output logic          out_valid,
  output logic [23:0]   out_rgb
);
  // reset: asserted at once, released after two clocks
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // scan position
  logic [RW-1:0] row_q, row_n, cur_row;
  logic [CW-1:0] col_q, col_n, cur_col;
  logic          col_wrap;

  always_comb begin
    cur_row  = in_sof ? '0 : row_q;               // R7
    cur_col  = in_sof ? '0 : col_q;
    col_wrap = in_eol || (cur_col >= cfg_cols);   // R8
    row_n    = cur_row;
    col_n    = cur_col + CW'(1);
    if (col_wrap) begin
      col_n = '0;
      row_n = (cur_row >= cfg_rows) ? '0 : cur_row + RW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      row_q <= '0;
      col_q <= '0;
    end else if (in_valid) begin                   // R9
      row_q <= row_n;
      col_q <= col_n;
    end
  end

  // datapath
  rgb_t            px;
  pix_t            luma;
  pix_t [1:0]      taps;
  pix_t            mag;

  assign px = rgb_t'(in_rgb);

  sobel_luma u_luma (
    .pix_i  (px),
    .luma_o (luma)
  );

  sobel_line_store #(
    .DEPTH (MAX_COLS),
    .LINES (2)
  ) u_lines (
    .clk    (clk),
    .wr_en  (in_valid && (cur_col < cfg_cols)),
    .addr   (cur_col[AW-1:0]),
    .din    (luma),
    .taps_o (taps)
  );

  sobel_window u_win (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .shift_en (in_valid),
    .top_i    (taps[1]),
    .mid_i    (taps[0]),
    .bot_i    (luma),
    .mag_o    (mag)
  );

  // output stage
  logic emit_n, border;
  pix_t edge_n, edge_q;
  logic emit_q;

  always_comb begin
    emit_n = in_valid && (cur_row != '0) && (cur_col != '0);      // R2
    border = (cur_row <= RW'(1)) || (cur_col <= CW'(1)) ||
             (cur_row >= cfg_rows) || (cur_col >= cfg_cols);     // R5
    edge_n = border ? '0 : mag;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      emit_q <= 1'b0;
      edge_q <= '0;
    end else begin
      emit_q <= emit_n;
      if (emit_n) edge_q <= edge_n;
    end
  end

  assign out_valid = emit_q;
  assign out_rgb   = {edge_q, edge_q, edge_q};                     // R6
endmodule

// File: rtl/sobel_edge_checker.sv
module sobel_edge_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_sof,
  input logic        out_valid,
  input logic [23:0] out_rgb
);
  // R2: an output only follows a beat
  assert_out_follows_beat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));

  // R9: an idle cycle produces nothing
  assert_idle_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R9: output data only moves together with a strobe
  assert_data_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_rgb) |-> out_valid);

  // R7: the frame-start beat is position (0,0), which emits nothing
  assert_sof_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sof) |=> !out_valid);

  // R10: nothing comes out while reset is applied
  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R10: assert (!out_valid && out_rgb == 24'h0);
    end
  end
endmodule

bind sobel_edge_stream sobel_edge_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_sof    (in_sof),
  .out_valid (out_valid),
  .out_rgb   (out_rgb)
);

// File: tb/sobel_edge_stream_test.sv
module sobel_edge_stream_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] cfg_cols, cfg_rows;
  logic        in_valid, in_sof, in_eol;
  logic [23:0] in_rgb;
  logic        out_valid;
  logic [23:0] out_rgb;

  always #5 clk = ~clk;

  sobel_edge_stream uut (
    .clk(clk), .rst_n(rst_n), .cfg_cols(cfg_cols), .cfg_rows(cfg_rows),
    .in_valid(in_valid), .in_sof(in_sof), .in_eol(in_eol), .in_rgb(in_rgb),
    .out_valid(out_valid), .out_rgb(out_rgb)
  );

  typedef struct {
    int    val;
    int    stamp;
    string tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  int   cyc   = 0;
  bit   done  = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // R1 reference brightness
  function automatic int bright(input logic [23:0] p);
    return (77 * int'(p[23:16]) + 150 * int'(p[15:8]) + 29 * int'(p[7:0])) >> 8;
  endfunction

  function automatic logic [23:0] pattern(input int kind, input int r, input int c);
    case (kind)
      0: return {8'(c * 20 + r * 3), 8'(r * 25), 8'(r * c * 7)};
      1: return ((r + c) % 2 == 1) ? 24'hFFFFFF : 24'h000000;
      2: return (c >= 1) ? 24'hFFFFFF : 24'h000000;
      default: return 24'((r * 131 + c * 197 + r * c * 53) * 40503);
    endcase
  endfunction

  task automatic report(input string tag, input int act, input int exp_v);
    n_chk++;
    if (act != exp_v) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
    end
  endtask

  // driver: scores the expected outputs and drives one (possibly cut) frame
  task automatic send_frame(input int rows, input int cols, input int kind,
                            input int last_col, input bit use_eol,
                            input int stop_after, input int gap_every, input string tag);
    int lum [0:15][0:15];
    int n = 0;
    for (int r = 0; r <= rows; r++) begin
      for (int c = 0; c <= last_col; c++) begin
        logic [23:0] p;
        if (n == stop_after) begin
          @(negedge clk);
          in_valid = 1'b0; in_sof = 1'b0; in_eol = 1'b0;
          return;
        end
        @(negedge clk);
        p        = pattern(kind, r, c);
        cfg_rows = 12'(rows);
        cfg_cols = 12'(cols);
        in_valid = 1'b1;
        in_sof   = (r == 0 && c == 0);
        in_eol   = use_eol && (c == last_col);
        in_rgb   = p;
        lum[r][c] = bright(p);
        if (r >= 1 && c >= 1) begin
          exp_t e;
          int gx, gy, s;
          if (r <= 1 || c <= 1 || r >= rows || c >= cols) begin
            s = 0;
            e.tag = {tag, " R5"};
          end else begin
            gx = 0; gy = 0;
            for (int i = 0; i < 3; i++) begin
              gx += (lum[r-2+i][c] - lum[r-2+i][c-2]) * ((i == 1) ? 2 : 1);
              gy += (lum[r][c-2+i] - lum[r-2][c-2+i]) * ((i == 1) ? 2 : 1);
            end
            s = (gx < 0 ? -gx : gx) + (gy < 0 ? -gy : gy);
            if (s > 255) begin
              s = 255;
              e.tag = {tag, " R4"};
            end else begin
              e.tag = {tag, " R1 R3"};
            end
          end
          e.val   = s;
          e.stamp = cyc + 1;
          q.push_back(e);
        end
        n++;
        if (gap_every > 0 && n % gap_every == 0) begin
          @(negedge clk);                   // R9: junk on an idle cycle
          in_valid = 1'b0;
          in_sof   = 1'b1;
          in_eol   = 1'b1;
          in_rgb   = 24'($urandom);
        end
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eol = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_valid) begin
        if (q.size() == 0) begin
          report("R2 unexpected output", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          report({e.tag, " R6 value"}, int'(out_rgb),
                 int'({8'(e.val), 8'(e.val), 8'(e.val)}));
          report("R2 timing", cyc, e.stamp);
        end
      end else if (q.size() > 0 && q[0].stamp <= cyc) begin
        report("R2 missing output", 0, 1);
        void'(q.pop_front());
      end
    end
  end

  task automatic finish_run();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    cfg_cols = 12'd8; cfg_rows = 12'd6;
    in_valid = 1'b0; in_sof = 1'b0; in_eol = 1'b0; in_rgb = '0;
    repeat (3) @(negedge clk);
    report("R10 reset valid", int'(out_valid), 0);
    report("R10 reset data", int'(out_rgb), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    report("R10 after release", int'(out_valid), 0);

    // ramps of all three colours, line-end flag given
    send_frame(6, 8, 0, 8, 1'b1, 1000, 0, "ramp");
    // checkerboard: clipping and border together
    send_frame(5, 7, 1, 7, 1'b1, 1000, 0, "checker");
    // step next to the left border, idle gaps with junk
    send_frame(6, 6, 2, 6, 1'b1, 1000, 3, "step R9");
    // line-end flag cuts scan rows short of cfg_cols
    send_frame(5, 10, 3, 5, 1'b1, 1000, 0, "eol R8");
    // no line-end flag: wrap by count alone
    send_frame(7, 9, 3, 9, 1'b0, 1000, 0, "count R8");
    // frame cut off in scan row 2, restarted with frame-start
    send_frame(4, 6, 3, 6, 1'b1, 20, 0, "cut R7");
    send_frame(5, 6, 0, 6, 1'b1, 1000, 2, "restart R7");

    repeat (6) @(negedge clk);
    report("R2 queue drained", q.size(), 0);
    finish_run();
  end
endmodule